// File: doc/BRIEF.md
# ORing Gate Controller

This block sequences the gate driver of an ideal-diode switch that joins a supply rail to a shared bus. A registered three-state machine waits in a precharge state until the charge pump has risen high enough. It then holds the pass transistor off until a forward drop appears across it. When a reverse condition, an over-voltage flag, a low enable or a charge-pump collapse occurs, it turns the transistor off again.

The block never switches the gate with a weak drive alone. Each turn-on and each turn-off from the on state starts with a strong pulse of fixed length and then falls back to a weak holding drive. Each pulse length is a number of ticks, and a tick is a parameterised number of clock cycles. The two charge-pump comparators give the precharge state hysteresis. A separate flag tells the downstream hot-swap logic that the charge pump is up.

Top module: `oring_gate_ctrl`

## Requirements
- R1: While rst_ni is low, and on the first cycles after it is released, the block is in precharge. gate_on_o is 0, cp_up_o is 0, and pd_hold_o is the only drive asserted. The reset acts asynchronously.
- R2: Precharge moves to off on the clock edge where cp_hi_i=1 and cp_lo_i=0. Precharge is kept while neither flag is set, and cp_lo_i=1 wins over cp_hi_i=1.
- R3: cp_lo_i=1 moves any state to precharge on the next edge. No strong pull-down pulse is issued on that move.
- R4: In the off state, fwd_i=1 together with en_i=1 and ov_i=0 moves the block to on at the next edge.
- R5: On entry to the on state, pu_fast_o is high for exactly PU_TICKS*TICK_DIV cycles. pu_hold_o is high after that for as long as the block stays on.
- R6: In the on state, rev_i=1 moves the block to off at the next edge and ends any pull-up pulse that is still running.
- R7: On entry to off from on, pd_fast_o is high for exactly PD_TICKS*TICK_DIV cycles and pd_hold_o follows it. On entry to off from precharge, pd_hold_o is asserted at once.
- R8: ov_i=1 or en_i=0 moves the on state to off, with a strong pull-down pulse. The same inputs keep the off state from turning on, whatever fwd_i is.
- R9: Exactly one of pu_fast_o, pu_hold_o, pd_fast_o and pd_hold_o is high in every cycle. gate_on_o is 1 exactly when a pull-up output is high.
- R10: cp_up_o is 1 in the off and on states and 0 in precharge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | ORing enable |
| ov_i | input | 1 | Over-voltage flag |
| cp_hi_i | input | 1 | Charge pump above upper threshold |
| cp_lo_i | input | 1 | Charge pump below lower threshold |
| fwd_i | input | 1 | Forward drop detected across the switch |
| rev_i | input | 1 | Reverse voltage detected |
| pu_fast_o | output | 1 | Strong gate pull-up pulse |
| pu_hold_o | output | 1 | Sustained weak pull-up |
| pd_fast_o | output | 1 | Strong gate pull-down pulse |
| pd_hold_o | output | 1 | Sustained pull-down |
| gate_on_o | output | 1 | Gate driven on (status) |
| cp_up_o | output | 1 | Charge pump up, gates the hot-swap section |

## Verification
The bench builds the block with TICK_DIV=2, PU_TICKS=4 and PD_TICKS=3. The pull-up pulse therefore lasts 8 cycles and the pull-down pulse lasts 6 cycles. With pulses this short, the bench can sample the last fast cycle and the first hold cycle of each pulse within a few vectors. It can also cut a pulse short, by reverse detection in one direction and by a fresh forward drop in the other, and check that the tick prescaler restarts on every new pulse.

// File: rtl/oring_pkg.sv
package oring_pkg;
  typedef enum logic [1:0] {
    ST_PRECHG = 2'd0,
    ST_OFF    = 2'd1,
    ST_ON     = 2'd2
  } oring_state_e;
endpackage

// File: rtl/oring_pulse_timer.sv
module oring_pulse_timer #(
  parameter int unsigned TICK_DIV = 50,
  parameter int unsigned TICKS    = 20
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  input  logic abort_i,
  output logic active_o
);
  localparam int unsigned PW = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;
  localparam int unsigned CW = $clog2(TICKS + 1);
  localparam logic [PW-1:0] PRE_LAST = PW'(TICK_DIV - 1);
  localparam logic [CW-1:0] CNT_INIT = CW'(TICKS);

  logic [PW-1:0] pre_q;
  logic [CW-1:0] cnt_q;

  // prescaler restarts on every start so pulse length is exact
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pre_q <= '0;
      cnt_q <= '0;
    end else if (start_i) begin
      pre_q <= '0;
      cnt_q <= CNT_INIT;
    end else if (abort_i) begin
      pre_q <= '0;
      cnt_q <= '0;
    end else if (cnt_q != '0) begin
      if (pre_q == PRE_LAST) begin
        pre_q <= '0;
        cnt_q <= cnt_q - 1'b1;
      end else begin
        pre_q <= pre_q + 1'b1;
      end
    end
  end

  assign active_o = (cnt_q != '0);
endmodule

// File: rtl/oring_fsm.sv
module oring_fsm
  import oring_pkg::*;
(
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         en_i,
  input  logic         ov_i,
  input  logic         cp_hi_i,
  input  logic         cp_lo_i,
  input  logic         fwd_i,
  input  logic         rev_i,
  output oring_state_e state_o,
  output logic         pu_start_o,
  output logic         pu_stop_o,
  output logic         pd_start_o,
  output logic         pd_stop_o
);
  oring_state_e state_q, state_d;
  logic         allow_on;

  assign allow_on = en_i && !ov_i;

  always_comb begin
    state_d = state_q;
    if (cp_lo_i) begin
      state_d = ST_PRECHG;
    end else begin
      unique case (state_q)
        ST_PRECHG: if (cp_hi_i)              state_d = ST_OFF;
        ST_OFF:    if (fwd_i && allow_on)    state_d = ST_ON;
        ST_ON:     if (rev_i || !allow_on)   state_d = ST_OFF;
        default:                             state_d = ST_PRECHG;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_PRECHG;
    else         state_q <= state_d;
  end

  assign pu_start_o = (state_q != ST_ON) && (state_d == ST_ON);
  assign pu_stop_o  = (state_q == ST_ON) && (state_d != ST_ON);
  assign pd_start_o = (state_q == ST_ON) && (state_d == ST_OFF);
  assign pd_stop_o  = (state_q == ST_OFF) && (state_d != ST_OFF);
  assign state_o    = state_q;
endmodule

// File: rtl/oring_gate_ctrl.sv
module oring_gate_ctrl
  import oring_pkg::*;
#(
  parameter int unsigned TICK_DIV = 50,
  parameter int unsigned PU_TICKS = 20,
  parameter int unsigned PD_TICKS = 15
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  input  logic ov_i,
  input  logic cp_hi_i,
  input  logic cp_lo_i,
  input  logic fwd_i,
  input  logic rev_i,
  output logic pu_fast_o,
  output logic pu_hold_o,
  output logic pd_fast_o,
  output logic pd_hold_o,
  output logic gate_on_o,
  output logic cp_up_o
);
  localparam int unsigned NPULSE = 2;
  localparam int unsigned PU_IDX = 0;
  localparam int unsigned PD_IDX = 1;

  oring_state_e      state;
  logic [NPULSE-1:0] p_start, p_stop, p_act;

  oring_fsm u_fsm (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .en_i      (en_i),
    .ov_i      (ov_i),
    .cp_hi_i   (cp_hi_i),
    .cp_lo_i   (cp_lo_i),
    .fwd_i     (fwd_i),
    .rev_i     (rev_i),
    .state_o   (state),
    .pu_start_o(p_start[PU_IDX]),
    .pu_stop_o (p_stop[PU_IDX]),
    .pd_start_o(p_start[PD_IDX]),
    .pd_stop_o (p_stop[PD_IDX])
  );

  for (genvar g = 0; g < NPULSE; g++) begin : g_pulse
    localparam int unsigned LEN = (g == PU_IDX) ? PU_TICKS : PD_TICKS;
    oring_pulse_timer #(
      .TICK_DIV(TICK_DIV),
      .TICKS   (LEN)
    ) u_tmr (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .start_i (p_start[g]),
      .abort_i (p_stop[g]),
      .active_o(p_act[g])
    );
  end

  always_comb begin
    pu_fast_o = 1'b0;
    pu_hold_o = 1'b0;
    pd_fast_o = 1'b0;
    pd_hold_o = 1'b0;
    unique case (state)
      ST_ON: begin
        pu_fast_o = p_act[PU_IDX];
        pu_hold_o = !p_act[PU_IDX];
      end
      ST_OFF: begin
        pd_fast_o = p_act[PD_IDX];
        pd_hold_o = !p_act[PD_IDX];
      end
      default: pd_hold_o = 1'b1;
    endcase
  end

  assign gate_on_o = (state == ST_ON);
  assign cp_up_o   = (state != ST_PRECHG);
endmodule

// File: rtl/oring_gate_ctrl_chk.sv
module oring_gate_ctrl_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic en_i,
  input logic ov_i,
  input logic cp_hi_i,
  input logic cp_lo_i,
  input logic fwd_i,
  input logic rev_i,
  input logic pu_fast_o,
  input logic pu_hold_o,
  input logic pd_fast_o,
  input logic pd_hold_o,
  input logic gate_on_o,
  input logic cp_up_o
);
  // R9
  one_drive_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones({pu_fast_o, pu_hold_o, pd_fast_o, pd_hold_o}) == 1);

  // R9
  gate_status_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    gate_on_o == (pu_fast_o || pu_hold_o));

  // R10
  on_needs_cp_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    gate_on_o |-> cp_up_o);

  // R3
  cp_drop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cp_lo_i |=> (!cp_up_o && pd_hold_o));

  // R2
  prechg_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cp_up_o && !cp_hi_i) |=> !cp_up_o);

  // R6
  rev_off_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (gate_on_o && rev_i && !cp_lo_i) |=> (!gate_on_o && pd_fast_o));

  // R8
  block_on_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!gate_on_o && (ov_i || !en_i)) |=> !gate_on_o);

  // R5
  on_entry_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(gate_on_o) |-> pu_fast_o);
endmodule

bind oring_gate_ctrl oring_gate_ctrl_chk u_chk (.*);

// File: tb/oring_gate_ctrl_bench.sv
module oring_gate_ctrl_bench;
  localparam int unsigned TICK_DIV = 2;
  localparam int unsigned PU_TICKS = 4;
  localparam int unsigned PD_TICKS = 3;
  localparam int unsigned PU_CYC = TICK_DIV * PU_TICKS;
  localparam int unsigned PD_CYC = TICK_DIV * PD_TICKS;
  localparam int NV = 24;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic en_i = 1'b0, ov_i = 1'b0, cp_hi_i = 1'b0, cp_lo_i = 1'b0, fwd_i = 1'b0, rev_i = 1'b0;
  logic pu_fast_o, pu_hold_o, pd_fast_o, pd_hold_o, gate_on_o, cp_up_o;
  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  oring_gate_ctrl #(
    .TICK_DIV(TICK_DIV),
    .PU_TICKS(PU_TICKS),
    .PD_TICKS(PD_TICKS)
  ) u_oring_gate_ctrl (
    .clk_i(clk), .rst_ni(rst_ni), .en_i(en_i), .ov_i(ov_i),
    .cp_hi_i(cp_hi_i), .cp_lo_i(cp_lo_i), .fwd_i(fwd_i), .rev_i(rev_i),
    .pu_fast_o(pu_fast_o), .pu_hold_o(pu_hold_o), .pd_fast_o(pd_fast_o),
    .pd_hold_o(pd_hold_o), .gate_on_o(gate_on_o), .cp_up_o(cp_up_o)
  );

  // {req, {en,ov,cp_hi,cp_lo,fwd,rev}, hold cycles, {gate,cp_up,pu_fast,pu_hold,pd_fast,pd_hold}}
  localparam logic [19:0] VEC [NV] = '{
    {4'd1,  6'b100000, 4'd1, 6'b000001},  // R1 still precharge
    {4'd2,  6'b101000, 4'd1, 6'b010001},  // R2 exit, R7 no pulse
    {4'd4,  6'b101010, 4'd1, 6'b111000},  // R4 turn on
    {4'd5,  6'b101010, 4'd6, 6'b111000},  // R5 last fast cycles
    {4'd5,  6'b101010, 4'd2, 6'b110100},  // R5 hold
    {4'd6,  6'b101001, 4'd1, 6'b010010},  // R6 reverse
    {4'd7,  6'b101000, 4'd4, 6'b010010},  // R7 still fast
    {4'd7,  6'b101000, 4'd1, 6'b010001},  // R7 hold
    {4'd8,  6'b001010, 4'd2, 6'b010001},  // R8 enable low blocks
    {4'd8,  6'b111010, 4'd2, 6'b010001},  // R8 ov blocks
    {4'd4,  6'b101010, 4'd1, 6'b111000},  // R4
    {4'd6,  6'b101001, 4'd1, 6'b010010},  // R6 cuts pull-up pulse
    {4'd9,  6'b101010, 4'd1, 6'b111000},  // R9 pd pulse cut, one drive
    {4'd5,  6'b101010, 4'd8, 6'b110100},  // R5 full length
    {4'd8,  6'b111010, 4'd1, 6'b010010},  // R8 ov forces off
    {4'd3,  6'b100100, 4'd1, 6'b000001},  // R3 from off
    {4'd2,  6'b101110, 4'd2, 6'b000001},  // R2 low wins
    {4'd2,  6'b100010, 4'd2, 6'b000001},  // R2 hysteresis
    {4'd2,  6'b101010, 4'd1, 6'b010001},  // R2 exit
    {4'd4,  6'b101010, 4'd1, 6'b111000},  // R4
    {4'd3,  6'b100110, 4'd1, 6'b000001},  // R3 from on, no pulse
    {4'd10, 6'b000000, 4'd1, 6'b000001},  // R10 precharge
    {4'd10, 6'b001000, 4'd1, 6'b010001},  // R10 off
    {4'd8,  6'b001010, 4'd3, 6'b010001}   // R8 enable low
  };

  function automatic logic [5:0] obs();
    return {gate_on_o, cp_up_o, pu_fast_o, pu_hold_o, pd_fast_o, pd_hold_o};
  endfunction

  task automatic check(input int req, input logic [5:0] exp, input string what);
    checks++;
    if (obs() !== exp) begin
      errors++;
      $display("FAIL R%0d %s actual=%b expected=%b", req, what, obs(), exp);
    end
  endtask

  task automatic put(input logic [5:0] v);
    {en_i, ov_i, cp_hi_i, cp_lo_i, fwd_i, rev_i} = v;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL R0 watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int n;
    // R1 in reset
    #5;
    check(1, 6'b000001, "reset state");
    repeat (2) @(negedge clk);
    rst_ni = 1'b1;
    check(1, 6'b000001, "after release");

    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      put(VEC[i][15:10]);
      repeat (int'(VEC[i][9:6])) @(posedge clk);
      @(negedge clk);
      check(int'(VEC[i][19:16]), VEC[i][5:0], $sformatf("vector %0d", i));
    end

    // R5 count pull-up pulse cycle by cycle
    put(6'b101000);
    @(negedge clk);
    put(6'b101010);
    @(posedge clk);
    @(negedge clk);
    n = 0;
    while (pu_fast_o && n < 40) begin
      n++;
      @(negedge clk);
    end
    checks++;
    if (n != PU_CYC) begin
      errors++;
      $display("FAIL R5 pulse length actual=%0d expected=%0d", n, PU_CYC);
    end
    check(5, 6'b110100, "hold after counted pulse");

    // R7 count pull-down pulse
    put(6'b101001);
    @(posedge clk);
    @(negedge clk);
    n = 0;
    while (pd_fast_o && n < 40) begin
      n++;
      @(negedge clk);
    end
    checks++;
    if (n != PD_CYC) begin
      errors++;
      $display("FAIL R7 pulse length actual=%0d expected=%0d", n, PD_CYC);
    end

    // R1 asynchronous reset while on
    put(6'b101010);
    repeat (2) @(posedge clk);
    @(negedge clk);
    check(4, 6'b111000, "on before reset");
    rst_ni = 1'b0;
    #1;
    check(1, 6'b000001, "async reset");
    @(negedge clk);
    rst_ni = 1'b1;
    put(6'b100000);
    @(posedge clk);
    @(negedge clk);
    check(1, 6'b000001, "precharge after reset");

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule